// File: doc/BRIEF.md
# Saturating Signed Add/Subtract Unit

This block performs signed two's-complement addition and subtraction that saturate instead of wrapping. A two-bit operation code picks one of three forms: `a + b`, `a - b`, or the reversed difference `b - a`. Both operands come in already sign-extended to the full data width. The block registers the result and a set of condition flags, and updates them one cycle after a qualified request.

When the exact mathematical result does not fit in the data width, the output clamps to the most positive or the most negative representable value. The zero and sign flags then describe the clamped value, not the wrapped one. The carry flag keeps the unsigned carry or borrow of the raw operation. The zero, sign, carry and overflow flags are recomputed from scratch on every accepted operation. The saturation flag is sticky: it accumulates overflow events until a synchronous clear input drops it.

A surrounding datapath uses the unit as its saturating ALU lane. It presents the operands with `in_valid` high, reads `result` and the flags on the following cycle, and pulses `sat_clr` when software wants to start a fresh saturation window.

Top module: `sat_addsub_unit`

## Requirements
- R1: With op code 0 (add), the registered result equals `opnd_a + opnd_b` when the signed sum fits in WIDTH bits.
- R2: With op code 1 (subtract), the registered result equals `opnd_a - opnd_b` when the signed difference fits.
- R3: With op code 2 (reverse subtract), the registered result equals `opnd_b - opnd_a` when the signed difference fits.
- R4: When the exact signed result exceeds the largest positive value, the result is 0 followed by all ones (for example 0x7FFFFFFF at WIDTH 32). The sign flag reads 0 and the zero flag reads 0.
- R5: When the exact signed result falls below the most negative value, the result is 1 followed by all zeros (for example 0x80000000). The sign flag reads 1 and the zero flag reads 0.
- R6: After any accepted operation, the zero flag is 1 exactly when the stored result is 0. The sign flag equals the stored result's top bit.
- R7: For add, the carry flag is the unsigned carry out of the top bit of `opnd_a + opnd_b`. This holds even when the result saturates.
- R8: For both subtract forms, the carry flag is 1 exactly when the minuend is unsigned-less-than the subtrahend. The minuend is `opnd_a` for op code 1 and `opnd_b` for op code 2.
- R9: The overflow flag is 1 exactly when the accepted operation saturated. It is recomputed, and may fall, on every accepted operation.
- R10: The saturation flag rises on any accepted overflowing operation. Otherwise it holds until a cycle with `sat_clr` high clears it. When a clear and an overflow arrive in the same cycle, the flag ends set.
- R11: A cycle with `in_valid` low, or with op code 3, leaves the result and the zero, sign, carry and overflow flags unchanged.
- R12: A synchronous active-high reset clears the result and all five flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies an operation in this cycle |
| op_sel | input | 2 | 0 add, 1 a minus b, 2 b minus a, 3 reserved (ignored) |
| opnd_a | input | WIDTH | First operand, signed |
| opnd_b | input | WIDTH | Second operand, signed |
| sat_clr | input | 1 | Synchronous clear of the sticky saturation flag |
| result | output | WIDTH | Registered saturated result |
| flag_zero | output | 1 | Stored result is zero |
| flag_sign | output | 1 | Top bit of stored result |
| flag_carry | output | 1 | Raw unsigned carry or borrow |
| flag_ovf | output | 1 | Last accepted operation saturated |
| flag_sat | output | 1 | Sticky saturation indicator |

## Verification
The hardest cases to reach are the saturation boundaries. The raw wrapped sum's sign is the opposite of the clamped value's, so a checker that reads the flags off the wrapped sum would report the wrong zero and sign. Hitting these cases at WIDTH 32 with random stimulus is rare. The bench therefore builds the unit at a 4-bit width and sweeps every operand pair under all three operation codes, which lands on each overflow edge, exact-zero and borrow case. It also drives `sat_clr` at a pattern tied to the operands, so clears meet both overflowing and clean operations in the same cycle.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_RSUB = 2'd2,
    OP_RSVD = 2'd3
  } sat_op_e;

  typedef struct packed {
    logic zero;
    logic sign;
    logic carry;
    logic ovf;
  } sat_cond_t;
endpackage

// File: rtl/sat_raw_arith.sv
// Wrapping add/subtract with raw carry/borrow and signed overflow detection.
module sat_raw_arith
  import sat_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  sat_op_e            op,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [WIDTH-1:0]   raw,
  output logic               carry,
  output logic               ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] x, y;
  logic [WIDTH:0]   ext;
  logic             is_add;

  always_comb begin
    is_add = (op == OP_ADD);
    // Reverse subtract swaps the operand roles so one subtractor serves both.
    if (op == OP_RSUB) begin
      x = b;
      y = a;
    end else begin
      x = a;
      y = b;
    end
    if (is_add) ext = {1'b0, x} + {1'b0, y};
    else        ext = {1'b0, x} - {1'b0, y};
    raw   = ext[MSB:0];
    carry = ext[WIDTH];
    if (is_add) ovf = (x[MSB] == y[MSB]) && (raw[MSB] != x[MSB]);
    else        ovf = (x[MSB] != y[MSB]) && (raw[MSB] != x[MSB]);
  end
endmodule

// File: rtl/sat_clamp.sv
// Replaces an overflowed value with the nearest signed extreme and derives
// zero/sign from the value that will actually be stored.
module sat_clamp #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] raw,
  input  logic             ovf,
  output logic [WIDTH-1:0] value,
  output logic             zero,
  output logic             sign
);
  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] MAX_POS = {1'b0, {MSB{1'b1}}};
  localparam logic [WIDTH-1:0] MIN_NEG = {1'b1, {MSB{1'b0}}};

  always_comb begin
    if (ovf && raw[MSB])      value = MAX_POS;  // wrapped negative: went too high
    else if (ovf)             value = MIN_NEG;  // wrapped positive: went too low
    else                      value = raw;
    zero = (value == '0);
    sign = value[MSB];
  end

  always_comb begin
    if (ovf) assert (!zero) else $error("AST_CLAMP_NONZERO");  // R4
  end
endmodule

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit
  import sat_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             sat_clr,
  output logic [WIDTH-1:0] result,
  output logic             flag_zero,
  output logic             flag_sign,
  output logic             flag_carry,
  output logic             flag_ovf,
  output logic             flag_sat
);
  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] MAX_POS = {1'b0, {MSB{1'b1}}};
  localparam logic [WIDTH-1:0] MIN_NEG = {1'b1, {MSB{1'b0}}};

  sat_op_e          op;
  logic [WIDTH-1:0] raw, clamped;
  logic             raw_cy, raw_ov, c_zero, c_sign, accept;
  sat_cond_t        cond_d, cond_q;

  assign op     = sat_op_e'(op_sel);
  assign accept = in_valid && (op != OP_RSVD);

  sat_raw_arith #(.WIDTH(WIDTH)) u_arith (
    .op(op), .a(opnd_a), .b(opnd_b),
    .raw(raw), .carry(raw_cy), .ovf(raw_ov)
  );

  sat_clamp #(.WIDTH(WIDTH)) u_clamp (
    .raw(raw), .ovf(raw_ov),
    .value(clamped), .zero(c_zero), .sign(c_sign)
  );

  always_comb begin
    cond_d.zero  = c_zero;
    cond_d.sign  = c_sign;
    cond_d.carry = raw_cy;
    cond_d.ovf   = raw_ov;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      cond_q   <= '0;
      flag_sat <= 1'b0;
    end else begin
      if (accept) begin
        result <= clamped;
        cond_q <= cond_d;
      end
      // A new overflow wins over a simultaneous clear.
      flag_sat <= (flag_sat && !sat_clr) || (accept && raw_ov);
    end
  end

  assign flag_zero  = cond_q.zero;
  assign flag_sign  = cond_q.sign;
  assign flag_carry = cond_q.carry;
  assign flag_ovf   = cond_q.ovf;

  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (rst)
    flag_sign == result[MSB]);  // R6
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    flag_zero |-> (result == '0));  // R6
  AST_CLAMP_POS: assert property (@(posedge clk) disable iff (rst)
    (flag_ovf && !flag_sign) |-> (result == MAX_POS));  // R4
  AST_CLAMP_NEG: assert property (@(posedge clk) disable iff (rst)
    (flag_ovf && flag_sign) |-> (result == MIN_NEG && !flag_zero));  // R5
  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_sat && !sat_clr) |=> flag_sat);  // R10
  AST_OVF_SETS_SAT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel != 2'd3) |=> (!flag_ovf || flag_sat));  // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || op_sel == 2'd3) |=> $stable(result));  // R11
endmodule

// File: tb/sat_addsub_unit_bench.sv
`timescale 1ns/1ps
module sat_addsub_unit_bench;
  localparam int W    = 4;
  localparam int MOD  = 1 << W;
  localparam int MAXP = (1 << (W-1)) - 1;
  localparam int MINN = -(1 << (W-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] op_sel = 2'd0;
  logic [W-1:0] opnd_a = '0, opnd_b = '0;
  logic sat_clr = 1'b0;
  logic [W-1:0] result;
  logic flag_zero, flag_sign, flag_carry, flag_ovf, flag_sat;

  int checks = 0;
  int errors = 0;
  int e_res = 0, e_z = 0, e_s = 0, e_cy = 0, e_ov = 0, e_sat = 0;

  always #2.5 clk = ~clk;

  sat_addsub_unit #(.WIDTH(W)) u_sat_addsub_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_clr(sat_clr),
    .result(result), .flag_zero(flag_zero), .flag_sign(flag_sign),
    .flag_carry(flag_carry), .flag_ovf(flag_ovf), .flag_sat(flag_sat)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle of stimulus, then compare every output with the model.
  task automatic step(input bit v, input int op, input int a, input int b, input bit clr);
    int sa, sb, tru, cyx, res;
    bit ovx, acc;
    @(negedge clk);
    in_valid = v; op_sel = op[1:0]; opnd_a = a[W-1:0]; opnd_b = b[W-1:0]; sat_clr = clr;
    @(posedge clk);
    #1;
    in_valid = 1'b0; sat_clr = 1'b0;
    sa = (a >= MOD/2) ? a - MOD : a;
    sb = (b >= MOD/2) ? b - MOD : b;
    case (op)
      0: begin tru = sa + sb; cyx = ((a + b) >= MOD) ? 1 : 0; end
      1: begin tru = sa - sb; cyx = (a < b) ? 1 : 0; end
      default: begin tru = sb - sa; cyx = (b < a) ? 1 : 0; end
    endcase
    ovx = (tru > MAXP) || (tru < MINN);
    acc = v && (op != 3);
    if (acc) begin
      res   = (tru > MAXP) ? MAXP : ((tru < MINN) ? MINN : tru);
      e_res = res & (MOD - 1);
      e_z   = (e_res == 0) ? 1 : 0;
      e_s   = (e_res >> (W-1)) & 1;
      e_cy  = cyx;
      e_ov  = ovx ? 1 : 0;
    end
    e_sat = ((e_sat != 0 && !clr) || (acc && ovx)) ? 1 : 0;
    if (!acc)             chk("R11 result held", int'(result), e_res);
    else if (tru > MAXP)  chk("R4 clamp high", int'(result), e_res);
    else if (tru < MINN)  chk("R5 clamp low", int'(result), e_res);
    else if (op == 0)     chk("R1 add", int'(result), e_res);
    else if (op == 1)     chk("R2 sub", int'(result), e_res);
    else                  chk("R3 rsub", int'(result), e_res);
    chk("R6 zero", int'(flag_zero), e_z);
    chk("R6 sign", int'(flag_sign), e_s);
    if (op == 0 || !acc)  chk("R7 carry", int'(flag_carry), e_cy);
    else                  chk("R8 borrow", int'(flag_carry), e_cy);
    chk("R9 overflow", int'(flag_ovf), e_ov);
    chk("R10 sticky sat", int'(flag_sat), e_sat);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R12 reset result", int'(result), 0);
    chk("R12 reset flags", int'({flag_zero, flag_sign, flag_carry, flag_ovf, flag_sat}), 0);
    // Full sweep; clear pulses whenever low operand bits match.
    for (int op = 0; op < 3; op++)
      for (int a = 0; a < MOD; a++)
        for (int b = 0; b < MOD; b++)
          step(1'b1, op, a, b, (a[1:0] == b[1:0]));
    // R11: reserved code and idle cycles with operands that would change state.
    step(1'b1, 0, 7, 1, 1'b0);       // overflow high, sat set
    step(1'b1, 3, 1, 1, 1'b0);       // reserved code ignored
    step(1'b0, 1, 8, 1, 1'b0);       // valid low ignored
    step(1'b0, 0, 0, 0, 1'b1);       // R10 clear alone
    step(1'b1, 1, 8, 1, 1'b1);       // R10 clear plus overflow: stays set
    step(1'b1, 0, 2, 3, 1'b0);       // R9 overflow falls, sat holds
    step(1'b1, 2, 3, 3, 1'b1);       // zero result, clear
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule